// File: doc/BRIEF.md
# Triggered Audio Clock Generator

This block turns one input clock into a pair of phase-locked audio timing outputs. One is a divided bit clock. The other is a frame sync pulse. Software programs the bit clock divisor, the frame length, the frame pulse width and a frame phase offset through four small registers. After that it sets the enable bit. The outputs stay low until a rising edge arrives on the trigger input. The trigger may be asynchronous and passes through a two-stage synchronizer. Both outputs then start together after a fixed latency.

A serial audio link needs a frame sync, a bit clock at 64 times the frame rate and a master clock at 256 times the frame rate. Two instances cover all three. The first instance drives the bit clock and frame sync, so those two keep a fixed phase to each other. The second instance drives the master clock. Divisor updates written while the block runs are held back until the next frame boundary, so a frame is never cut short.

Top module: `audio_clkgen`

## Requirements
- R1: After reset both outputs are low, the running status bit is 0 and all four registers read as zero.
- R2: Register map, selected by `reg_addr`:
  - Address 0 is control. Bit 0 is enable (read/write). Bit 1 is running status (read-only).
  - Address 1 holds the bit clock divisor in bits [19:0].
  - Address 2 holds the frame length in input cycles in bits [19:0].
  - Address 3 holds the frame phase in bits [19:0] and the pulse width in bits [31:24].
  - Every other bit reads 0.
- R3: A rising trigger is accepted only while the block is enabled and idle. When the trigger goes high between clock edges, both outputs start on the third rising edge after that change. In that first cycle the bit clock is high and the running status bit reads 1.
- R4: The bit clock period equals the divisor in input cycles. A divisor below 2 acts as 2. An even divisor gives equal high and low phases. An odd divisor gives a high phase one cycle longer than the low phase, and each period begins with its high phase.
- R5: The frame sync repeats every frame length input cycles, with a minimum of 2. It is high for the pulse width times the bit clock divisor input cycles. A pulse width of 0 gives a single input cycle.
- R6: At the start the frame counter is loaded with the phase value. The frame pulse is therefore high in the first cycle only if the phase is below the pulse length, and the next frame begins after frame length minus phase cycles. A phase not below the frame length is treated as 0.
- R7: A trigger edge that arrives while enable is 0 has no effect. It does not start the outputs, either then or after a later enable.
- R8: A write that clears enable forces both outputs low and the status bit to 0 on the same clock edge that takes the write.
- R9: Divisor, frame length and pulse width writes made while running take effect at the next frame boundary. The bit clock counter carries on with the new divisor from that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| trig_in | input | 1 | Start trigger, may be asynchronous |
| bclk_out | output | 1 | Divided bit clock output |
| fsync_out | output | 1 | Frame sync output |

## Verification
The generator is run with several divisor sets, and each output cycle is compared with a model that depends only on the cycle index:
- An even divisor with a one-period pulse checks duty cycle and frame alignment.
- An odd divisor with a zero pulse width separates the longer high phase and the single-cycle pulse.
- A nonzero phase shows that the frame counter is preloaded rather than started at zero.
- Divisor 1 with an oversized phase exercises both clamps.
- A wider pulse checks the width-times-divisor product.

A mid-frame divisor change is checked both before and after the frame boundary. Trigger edges are tested while the block is enabled and while it is disabled, to separate the two cases.

// File: rtl/acg_pkg.sv
package acg_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CLKDIV = 2'd1,
        ADDR_FSDIV  = 2'd2,
        ADDR_FSCFG  = 2'd3
    } acg_addr_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RUN_BIT = 1;

endpackage

// File: rtl/acg_regs.sv
module acg_regs
    import acg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 20,
    parameter int PW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              running,
    output logic              en_eff,
    output logic [DIV_W-1:0]  cdiv,
    output logic [DIV_W-1:0]  fdiv,
    output logic [PW_W-1:0]   pw,
    output logic [DIV_W-1:0]  phase,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] cdiv;
        logic [DIV_W-1:0] fdiv;
        logic [PW_W-1:0]  pw;
        logic [DIV_W-1:0] phase;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wbits;

    // Next-state logic for the register file.
    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (acg_addr_e'(addr))
                ADDR_CTRL:   r_d.en    = wdata[CTRL_EN_BIT];
                ADDR_CLKDIV: r_d.cdiv  = wdata[DIV_W-1:0];
                ADDR_FSDIV:  r_d.fdiv  = wdata[DIV_W-1:0];
                ADDR_FSCFG: begin
                    r_d.phase = wdata[DIV_W-1:0];
                    r_d.pw    = wdata[DATA_W-1 -: PW_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // A write that clears enable takes effect in the core on the same edge.
    assign en_eff = r_d.en;
    assign cdiv   = r_q.cdiv;
    assign fdiv   = r_q.fdiv;
    assign pw     = r_q.pw;
    assign phase  = r_q.phase;

    always_comb begin
        rdata = '0;
        case (acg_addr_e'(addr))
            ADDR_CTRL: begin
                rdata[CTRL_EN_BIT]  = r_q.en;
                rdata[CTRL_RUN_BIT] = running;
            end
            ADDR_CLKDIV: rdata[DIV_W-1:0] = r_q.cdiv;
            ADDR_FSDIV:  rdata[DIV_W-1:0] = r_q.fdiv;
            ADDR_FSCFG: begin
                rdata[DIV_W-1:0]        = r_q.phase;
                rdata[DATA_W-1 -: PW_W] = r_q.pw;
            end
            default: ;
        endcase
    end

    assign unused_wbits = ^wdata;

endmodule

// File: rtl/acg_trig_sync.sv
module acg_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rise
);

    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], trig};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // Edge detect on the last synchronizer stage.
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/acg_core.sv
module acg_core #(
    parameter int DIV_W = 20,
    parameter int PW_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [DIV_W-1:0] cdiv_cfg,
    input  logic [DIV_W-1:0] fdiv_cfg,
    input  logic [PW_W-1:0]  pw_cfg,
    input  logic [DIV_W-1:0] phase_cfg,
    output logic             bclk,
    output logic             fsync,
    output logic             running
);

    localparam int LEN_W = DIV_W + PW_W;

    typedef struct packed {
        logic             running;
        logic             bclk;
        logic             fs;
        logic [DIV_W-1:0] ccnt;
        logic [DIV_W-1:0] fcnt;
        logic [DIV_W-1:0] cdiv_a;
        logic [DIV_W-1:0] fdiv_a;
        logic [PW_W-1:0]  pw_a;
    } core_t;

    core_t st_d, st_q;

    function automatic logic [DIV_W-1:0] clamp2(input logic [DIV_W-1:0] v);
        return (v < DIV_W'(2)) ? DIV_W'(2) : v;
    endfunction

    function automatic logic [DIV_W:0] high_len(input logic [DIV_W-1:0] c);
        return ({1'b0, c} + (DIV_W+1)'(1)) >> 1;
    endfunction

    function automatic logic [LEN_W-1:0] fs_len(input logic [PW_W-1:0] w,
                                                 input logic [DIV_W-1:0] c);
        return (w == '0) ? LEN_W'(1) : (LEN_W'(w) * LEN_W'(c));
    endfunction

    logic [DIV_W-1:0] cd_reg, fd_reg, cd_use, ph_use;
    logic [PW_W-1:0]  pw_use;
    logic [DIV_W:0]   cinc, finc;
    logic             wrap;

    always_comb begin
        st_d   = st_q;
        cd_reg = clamp2(cdiv_cfg);
        fd_reg = clamp2(fdiv_cfg);
        ph_use = (phase_cfg < fd_reg) ? phase_cfg : '0;
        cinc   = {1'b0, st_q.ccnt} + (DIV_W+1)'(1);
        finc   = {1'b0, st_q.fcnt} + (DIV_W+1)'(1);
        wrap   = finc >= {1'b0, st_q.fdiv_a};
        cd_use = wrap ? cd_reg : st_q.cdiv_a;
        pw_use = wrap ? pw_cfg : st_q.pw_a;

        if (!en) begin
            st_d.running = 1'b0;
            st_d.bclk    = 1'b0;
            st_d.fs      = 1'b0;
            st_d.ccnt    = '0;
            st_d.fcnt    = '0;
        end else if (!st_q.running) begin
            if (start) begin
                st_d.running = 1'b1;
                st_d.cdiv_a  = cd_reg;
                st_d.fdiv_a  = fd_reg;
                st_d.pw_a    = pw_cfg;
                st_d.ccnt    = '0;
                st_d.fcnt    = ph_use;
                st_d.bclk    = 1'b1;
                st_d.fs      = LEN_W'(ph_use) < fs_len(pw_cfg, cd_reg);
            end
        end else begin
            if (wrap) begin
                st_d.fcnt   = '0;
                st_d.cdiv_a = cd_reg;
                st_d.fdiv_a = fd_reg;
                st_d.pw_a   = pw_cfg;
            end else begin
                st_d.fcnt   = finc[DIV_W-1:0];
            end
            st_d.ccnt = (cinc >= {1'b0, cd_use}) ? '0 : cinc[DIV_W-1:0];
            st_d.bclk = {1'b0, st_d.ccnt} < high_len(cd_use);
            st_d.fs   = LEN_W'(st_d.fcnt) < fs_len(pw_use, cd_use);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk    = st_q.bclk;
    assign fsync   = st_q.fs;
    assign running = st_q.running;

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
    parameter int DATA_W      = 32,
    parameter int DIV_W       = 20,
    parameter int PW_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              trig_in,
    output logic              bclk_out,
    output logic              fsync_out
);

    logic             en_eff, trig_rise, running;
    logic [DIV_W-1:0] cdiv, fdiv, phase;
    logic [PW_W-1:0]  pw;

    acg_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PW_W(PW_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .running (running),
        .en_eff  (en_eff),
        .cdiv    (cdiv),
        .fdiv    (fdiv),
        .pw      (pw),
        .phase   (phase),
        .rdata   (reg_rdata)
    );

    acg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_in),
        .rise  (trig_rise)
    );

    acg_core #(.DIV_W(DIV_W), .PW_W(PW_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_eff),
        .start     (trig_rise),
        .cdiv_cfg  (cdiv),
        .fdiv_cfg  (fdiv),
        .pw_cfg    (pw),
        .phase_cfg (phase),
        .bclk      (bclk_out),
        .fsync     (fsync_out),
        .running   (running)
    );

endmodule

// File: rtl/acg_chk.sv
module acg_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_in,
    input logic dis_wr,
    input logic bclk_out,
    input logic fsync_out,
    input logic running
);

    // R3
    start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(trig_in, 3));

    // R3
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> bclk_out);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!bclk_out && !fsync_out));

    // R8
    disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> (!running && !bclk_out && !fsync_out));

endmodule

bind audio_clkgen acg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .dis_wr    (reg_wr && (reg_addr == 2'd0) && !reg_wdata[0]),
    .bclk_out  (bclk_out),
    .fsync_out (fsync_out),
    .running   (running)
);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        trig_in;
    logic        bclk_out;
    logic        fsync_out;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #10 clk = ~clk;

    audio_clkgen u_audio_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_in   (trig_in),
        .bclk_out  (bclk_out),
        .fsync_out (fsync_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic configure(input int c, input int f, input int w, input int ph);
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd1, 32'(c));
        wr_reg(2'd2, 32'(f));
        wr_reg(2'd3, {8'(w), 4'h0, 20'(ph)});
        wr_reg(2'd0, 32'd1);
    endtask

    // Trigger rises at a falling edge; returns just after the first rising edge.
    task automatic fire();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    function automatic logic exp_bclk(input int i, input int c);
        return (i % c) < ((c + 1) / 2);
    endfunction

    function automatic logic exp_fs(input int i, input int c, input int f,
                                    input int w, input int ph);
        int len = (w == 0) ? 1 : w * c;
        return ((ph + i) % f) < len;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "bclk", 32'(bclk_out), 0);
        check("R1", "fsync", 32'(fsync_out), 0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), d);
            check("R1", "reg", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(2'd1, 32'hFFFA_BCDE);
        rd_reg(2'd1, d); check("R2", "clkdiv", d, 32'h000A_BCDE);
        wr_reg(2'd2, 32'h0001_2345);
        rd_reg(2'd2, d); check("R2", "fsdiv", d, 32'h0001_2345);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd3, d); check("R2", "fscfg", d, 32'hFF0F_FFFF);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check("R2", "ctrl", d, 32'h0000_0001);
        wr_reg(2'd0, 32'd0);
    endtask

    // R3 latency followed by R8 disable while the bit clock would stay high.
    task automatic t_latency_disable();
        logic [31:0] d;
        configure(8, 32, 1, 0);
        fire();
        check("R3", "bclk after edge 1", 32'(bclk_out), 0);
        @(negedge clk);
        check("R3", "bclk after edge 2", 32'(bclk_out), 0);
        @(negedge clk);
        check("R3", "bclk after edge 3", 32'(bclk_out), 1);
        check("R3", "fsync after edge 3", 32'(fsync_out), 1);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd0;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8", "bclk after disable", 32'(bclk_out), 0);
        check("R8", "fsync after disable", 32'(fsync_out), 0);
        rd_reg(2'd0, d); check("R8", "status after disable", d, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        configure(4, 16, 1, 0);
        fire();
        repeat (3) @(negedge clk);
        rd_reg(2'd0, d); check("R3", "status running", d, 32'd3);
        wr_reg(2'd0, 32'd0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr_reg(2'd0, 32'd0);
        fire();
        repeat (4) @(negedge clk);
        check("R7", "bclk disabled", 32'(bclk_out), 0);
        rd_reg(2'd0, d); check("R7", "status disabled", d, 0);
        wr_reg(2'd0, 32'd1);
        repeat (6) @(negedge clk);
        check("R7", "bclk after enable", 32'(bclk_out), 0);
        check("R7", "fsync after enable", 32'(fsync_out), 0);
        rd_reg(2'd0, d); check("R7", "status after enable", d, 32'd1);
    endtask

    task automatic run_pattern(input string req, input int c, input int f,
                               input int w, input int ph, input int n);
        int ce = (c < 2) ? 2 : c;
        int fe = (f < 2) ? 2 : f;
        int pe = (ph < fe) ? ph : 0;
        configure(c, f, w, ph);
        fire();
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            check(req, $sformatf("bclk cycle %0d", i), 32'(bclk_out),
                  32'(exp_bclk(i, ce)));
            check(req, $sformatf("fsync cycle %0d", i), 32'(fsync_out),
                  32'(exp_fs(i, ce, fe, w, pe)));
        end
        wr_reg(2'd0, 32'd0);
    endtask

    task automatic t_change();
        configure(4, 16, 1, 0);
        fire();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            logic eb, ef;
            if (i > 0) @(negedge clk);
            if (i < 16) begin
                eb = exp_bclk(i, 4);
                ef = exp_fs(i, 4, 16, 1, 0);
            end else begin
                eb = exp_bclk(i - 16, 2);
                ef = exp_fs(i - 16, 2, 8, 1, 0);
            end
            check("R9", $sformatf("bclk cycle %0d", i), 32'(bclk_out), 32'(eb));
            check("R9", $sformatf("fsync cycle %0d", i), 32'(fsync_out), 32'(ef));
            if (i == 5) begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd2;
            end else if (i == 6) begin
                reg_addr = 2'd2; reg_wdata = 32'd8;
            end else if (i == 7) begin
                reg_wr = 1'b0;
            end
        end
        wr_reg(2'd0, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; trig_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_latency_disable();
        t_status();
        t_ignored();
        run_pattern("R4", 4, 16, 1, 0, 40);
        run_pattern("R4", 5, 20, 0, 0, 45);
        run_pattern("R5", 2, 16, 3, 0, 36);
        run_pattern("R6", 4, 16, 1, 6, 40);
        run_pattern("R6", 1, 8, 1, 9, 20);
        t_change();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule